// File: doc/BRIEF.md
# I2C Byte Transmit Master

This block is the transmit half of an I2C controller. It drives two open-drain lines, SCL and SDA, through drive-low enables and reads the levels actually present on the wires. A byte-level command port feeds it. Each accepted command carries one byte plus two flags. One flag opens a transaction with a START, or with a repeated START if a transaction is already open. The other flag closes the transaction with a STOP once that byte has been acknowledged. Between bytes the engine parks with SCL held low and waits for the next command.

Every byte goes out most significant bit first. After the eighth bit the engine releases SDA for a ninth clock and samples the receiver's acknowledge. If no acknowledge arrives, the engine sets a sticky error flag, drives a STOP on its own and suspends the transaction. It then discards byte commands until software issues a soft reset or opens a new transaction. A separate line monitor watches the synchronized wires for START and STOP patterns from any master and derives a bus-busy flag from them. SCL timing comes from a quarter-period divider with one count for 100 kHz and another for 400 kHz, chosen by a mode input.

Top module: `i2c_tx_master`

## Requirements
- R1: After hardware reset, scl_oe and sda_oe are 0 (both lines released), busy and err are 0, and cmd_ready is 1.
- R2: While a byte is on the bus, every SCL high pulse lasts exactly 2*QTR_STD clock cycles when fast_mode is 0 and 2*QTR_FAST cycles when fast_mode is 1. SCL low phases inside a byte last the same length.
- R3: busy goes to 1 a few cycles after SDA falls while SCL is high, whether the block or another master caused it. busy returns to 0 a few cycles after SDA rises while SCL is high. The block's own bus activity does not drive busy directly.
- R4: While a byte or its acknowledge clock is in progress, sda_oe changes only while SCL is driven low. SDA moves while SCL is high only to form START and STOP.
- R5: Each byte is sent MSB first on eight SCL pulses, and SDA is released for a ninth pulse. SDA sampled low during that pulse gives a one-cycle xfer_done with xfer_ack=1.
- R6: If SDA is sampled high on the ninth pulse, xfer_done pulses with xfer_ack=0 in the same cycle that err rises to 1. The engine then drives a STOP and releases both lines.
- R7: While err is 1, a command with cmd_first=0 is accepted and dropped. It causes no SCL pulse, no line change and no xfer_done.
- R8: A command with cmd_first=1 accepted while idle clears err and starts a new transaction with START.
- R9: With cmd_last=0, the engine holds SCL low and SDA released after the acknowledge clock until the next command. A next command with cmd_first=1 produces a repeated START, and one with cmd_last=1 ends with STOP.
- R10: A one-cycle soft_rst clears err and busy, releases both lines and returns the engine to idle (cmd_ready=1) at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| fast_mode | input | 1 | 0 selects 100 kHz quarter count, 1 selects 400 kHz |
| cmd_valid | input | 1 | A byte command is offered |
| cmd_first | input | 1 | Precede this byte with START (or repeated START) |
| cmd_last | input | 1 | Follow this byte with STOP after its acknowledge |
| cmd_data | input | 8 | Byte to transmit |
| cmd_ready | output | 1 | Engine can take a command this cycle |
| xfer_done | output | 1 | One-cycle pulse when a byte's acknowledge clock ends |
| xfer_ack | output | 1 | Acknowledge seen for the byte, valid with xfer_done |
| scl_i | input | 1 | Level present on the SCL wire |
| sda_i | input | 1 | Level present on the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A START has been seen on the wires and no STOP since |
| err | output | 1 | Sticky flag: a byte was not acknowledged |

## Verification
The bench sweeps address and data patterns through both speed modes, including all-zero and all-one bytes. A bit-order slip or an off-by-one quarter would show up as a wrong byte at the model receiver or a wrong SCL high width. Missing acknowledges are placed on the address byte and on a middle data byte. A design that kept clocking after a missing acknowledge, or that honoured the queued byte after the automatic STOP, would produce extra bytes or done pulses at the receiver. A held transaction checks that SCL stays low between commands and that a repeated START is counted as a second START. A busy flag taken from internal state instead of the wires would miss a START made by another master on an idle block.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int BIDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_STOP
    } eng_state_e;

    typedef struct packed {
        eng_state_e           st;
        logic [1:0]           q;
        logic [BIDX_W-1:0]    bidx;
        logic [BYTE_W-1:0]    sh;
        logic                 last;
        logic                 scl_low;
        logic                 sda_low;
        logic                 err;
        logic                 done;
        logic                 ack;
    } eng_regs_s;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_comb begin
            stg_d[g] = stg_q[g-1];
        end
    end

    // lines idle high, so reset the chain to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/i2cm_qtr_div.sv
module i2cm_qtr_div #(
    parameter int QTR_STD  = 125,
    parameter int QTR_FAST = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic clr,
    input  logic fast,
    output logic qtick
);
    localparam int QMAX = (QTR_STD > QTR_FAST) ? QTR_STD : QTR_FAST;
    localparam int CW   = $clog2(QMAX + 1);
    localparam logic [CW-1:0] LIM_STD  = CW'(QTR_STD - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(QTR_FAST - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = fast ? LIM_FAST : LIM_STD;
        qtick = !clr && (cnt_q == lim);
        if (clr || soft_rst || cnt_q == lim) cnt_d = '0;
        else                                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic busy
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic busy;
    } mon_regs_s;

    mon_regs_s mon_d, mon_q;
    logic start_seen, stop_seen;

    always_comb begin
        start_seen = mon_q.scl_p && scl_s && mon_q.sda_p && !sda_s;
        stop_seen  = mon_q.scl_p && scl_s && !mon_q.sda_p && sda_s;
        mon_d       = mon_q;
        mon_d.scl_p = scl_s;
        mon_d.sda_p = sda_s;
        if (start_seen)     mon_d.busy = 1'b1;
        else if (stop_seen) mon_d.busy = 1'b0;
        if (soft_rst)       mon_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0};
        else        mon_q <= mon_d;
    end

    assign busy = mon_q.busy;
endmodule

// File: rtl/i2cm_tx_engine.sv
module i2cm_tx_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              qtick,
    input  logic              sda_s,
    input  logic              cmd_valid,
    input  logic              cmd_first,
    input  logic              cmd_last,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_ready,
    output logic              div_clr,
    output logic              in_byte,
    output logic              scl_low,
    output logic              sda_low,
    output logic              err,
    output logic              xfer_done,
    output logic              xfer_ack
);
    localparam logic [BIDX_W-1:0] BIDX_TOP = BIDX_W'(BYTE_W - 1);
    localparam eng_regs_s ENG_RST = '{
        st: ST_IDLE, q: 2'd0, bidx: '0, sh: '0, last: 1'b0,
        scl_low: 1'b0, sda_low: 1'b0, err: 1'b0, done: 1'b0, ack: 1'b0
    };

    eng_regs_s eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                // byte commands without a start flag are dropped here
                if (cmd_valid && cmd_first) begin
                    eng_d.st   = ST_START;
                    eng_d.q    = 2'd0;
                    eng_d.sh   = cmd_data;
                    eng_d.last = cmd_last;
                    eng_d.err  = 1'b0;
                end
            end
            ST_HOLD: begin
                if (cmd_valid) begin
                    eng_d.q    = 2'd0;
                    eng_d.sh   = cmd_data;
                    eng_d.last = cmd_last;
                    eng_d.bidx = BIDX_TOP;
                    eng_d.st   = cmd_first ? ST_START : ST_BIT;
                end
            end
            ST_START: begin
                if (qtick) begin
                    eng_d.q = eng_q.q + 2'd1;
                    unique case (eng_q.q)
                        2'd0: eng_d.sda_low = 1'b0;
                        2'd1: eng_d.scl_low = 1'b0;
                        2'd2: eng_d.sda_low = 1'b1;
                        default: begin
                            eng_d.scl_low = 1'b1;
                            eng_d.bidx    = BIDX_TOP;
                            eng_d.st      = ST_BIT;
                        end
                    endcase
                end
            end
            ST_BIT: begin
                if (qtick) begin
                    eng_d.q = eng_q.q + 2'd1;
                    unique case (eng_q.q)
                        2'd0: eng_d.sda_low = !eng_q.sh[BYTE_W-1];
                        2'd1: eng_d.scl_low = 1'b0;
                        2'd2: ;
                        default: begin
                            eng_d.scl_low = 1'b1;
                            eng_d.sh      = {eng_q.sh[BYTE_W-2:0], 1'b0};
                            if (eng_q.bidx == '0) eng_d.st = ST_ACK;
                            else                  eng_d.bidx = eng_q.bidx - 1'b1;
                        end
                    endcase
                end
            end
            ST_ACK: begin
                if (qtick) begin
                    eng_d.q = eng_q.q + 2'd1;
                    unique case (eng_q.q)
                        2'd0: eng_d.sda_low = 1'b0;
                        2'd1: eng_d.scl_low = 1'b0;
                        2'd2: eng_d.ack     = !sda_s;
                        default: begin
                            eng_d.scl_low = 1'b1;
                            eng_d.done    = 1'b1;
                            if (!eng_q.ack) begin
                                eng_d.err = 1'b1;
                                eng_d.st  = ST_STOP;
                            end else begin
                                eng_d.st = eng_q.last ? ST_STOP : ST_HOLD;
                            end
                        end
                    endcase
                end
            end
            ST_STOP: begin
                if (qtick) begin
                    eng_d.q = eng_q.q + 2'd1;
                    unique case (eng_q.q)
                        2'd0: eng_d.sda_low = 1'b1;
                        2'd1: eng_d.scl_low = 1'b0;
                        2'd2: eng_d.sda_low = 1'b0;
                        default: eng_d.st   = ST_IDLE;
                    endcase
                end
            end
            default: eng_d = ENG_RST;
        endcase
        if (soft_rst) eng_d = ENG_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign cmd_ready = (eng_q.st == ST_IDLE) || (eng_q.st == ST_HOLD);
    assign div_clr   = cmd_ready;
    assign in_byte   = (eng_q.st == ST_BIT) || (eng_q.st == ST_ACK);
    assign scl_low   = eng_q.scl_low;
    assign sda_low   = eng_q.sda_low;
    assign err       = eng_q.err;
    assign xfer_done = eng_q.done;
    assign xfer_ack  = eng_q.ack;
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
    parameter int QTR_STD     = 125,
    parameter int QTR_FAST    = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       fast_mode,
    input  logic       cmd_valid,
    input  logic       cmd_first,
    input  logic       cmd_last,
    input  logic [7:0] cmd_data,
    output logic       cmd_ready,
    output logic       xfer_done,
    output logic       xfer_ack,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       err
);
    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       qtick, div_clr;
    logic       byte_phase;

    i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cm_bus_mon u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .busy    (busy)
    );

    i2cm_qtr_div #(.QTR_STD(QTR_STD), .QTR_FAST(QTR_FAST)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .clr     (div_clr),
        .fast    (fast_mode),
        .qtick   (qtick)
    );

    i2cm_tx_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .qtick    (qtick),
        .sda_s    (sda_s),
        .cmd_valid(cmd_valid),
        .cmd_first(cmd_first),
        .cmd_last (cmd_last),
        .cmd_data (cmd_data),
        .cmd_ready(cmd_ready),
        .div_clr  (div_clr),
        .in_byte  (byte_phase),
        .scl_low  (scl_oe),
        .sda_low  (sda_oe),
        .err      (err),
        .xfer_done(xfer_done),
        .xfer_ack (xfer_ack)
    );
endmodule

// File: rtl/i2c_tx_master_chk.sv
module i2c_tx_master_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic cmd_valid,
    input logic cmd_first,
    input logic cmd_ready,
    input logic xfer_done,
    input logic xfer_ack,
    input logic sda_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic err,
    input logic byte_phase
);
    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_phase && $past(byte_phase) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R5

    AST_ERR_RISE_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (xfer_done && !xfer_ack)); // R6

    AST_ERR_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (err && cmd_valid && cmd_ready && !cmd_first && !soft_rst) |=> (!scl_oe && !sda_oe && !xfer_done)); // R7

    AST_SOFT_RST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!err && !busy && !scl_oe && !sda_oe && cmd_ready)); // R10

    AST_BUSY_FALL_SDA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(soft_rst)) |-> $past(sda_i)); // R3
endmodule

bind i2c_tx_master i2c_tx_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cmd_valid (cmd_valid),
    .cmd_first (cmd_first),
    .cmd_ready (cmd_ready),
    .xfer_done (xfer_done),
    .xfer_ack  (xfer_ack),
    .sda_i     (sda_i),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .err       (err),
    .byte_phase(byte_phase)
);

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QS = 6;
    localparam int QF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic fast_mode = 1'b0;
    logic cmd_valid = 1'b0, cmd_first = 1'b0, cmd_last = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic cmd_ready, xfer_done, xfer_ack, scl_oe, sda_oe, busy, err;
    logic ext_scl_low = 1'b0, ext_sda_low = 1'b0, slv_sda_low = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = !(scl_oe || ext_scl_low);
    assign sda_line = !(sda_oe || ext_sda_low || slv_sda_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tx_master #(.QTR_STD(QS), .QTR_FAST(QF)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fast_mode(fast_mode),
        .cmd_valid(cmd_valid), .cmd_first(cmd_first), .cmd_last(cmd_last),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .xfer_done(xfer_done),
        .xfer_ack(xfer_ack), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .err(err)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0;

    // receiver model state
    logic scl_p = 1'b1, sda_p = 1'b1;
    int bitcnt = 0, t_rise = 0, cur_q = QS;
    logic in_frame = 1'b0, rise_seen = 1'b0, busy_seen = 1'b0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] rx [64];
    logic done_ack [64];
    int rx_n = 0, done_n = 0, start_n = 0, stop_n = 0, nack_at = -1;
    int width_n = 0, width_bad = 0;

    always @(negedge clk) begin
        cyc++;
        if (busy) busy_seen = 1'b1;
        if (xfer_done && done_n < 64) begin
            done_ack[done_n] = xfer_ack;
            done_n++;
        end
        if (scl_p && scl_line && sda_p && !sda_line) begin
            start_n++; in_frame = 1'b1; bitcnt = 0; rise_seen = 1'b0;
        end else if (scl_p && scl_line && !sda_p && sda_line) begin
            stop_n++; in_frame = 1'b0; slv_sda_low = 1'b0;
        end else if (in_frame && !scl_p && scl_line) begin
            t_rise = cyc; rise_seen = 1'b1;
            if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
            bitcnt++;
        end else if (in_frame && scl_p && !scl_line) begin
            if (rise_seen) begin
                width_n++;
                if (cyc - t_rise != 2*cur_q) width_bad++;
            end
            if (bitcnt == 8) begin
                if (rx_n < 64) rx[rx_n] = shreg;
                slv_sda_low = (rx_n != nack_at);
                rx_n++;
            end else if (bitcnt == 9) begin
                slv_sda_low = 1'b0;
                bitcnt = 0;
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic first, input logic last, input logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_first = first; cmd_last = last; cmd_data = data;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_first = 1'b0; cmd_last = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || !cmd_ready || scl_oe || sda_oe) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_log(input int nack);
        rx_n = 0; done_n = 0; nack_at = nack; busy_seen = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int s0, p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 scl_oe", 32'(scl_oe), 0);
        check("R1 sda_oe", 32'(sda_oe), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 err", 32'(err), 0);
        check("R1 cmd_ready", 32'(cmd_ready), 1);

        // R2 R5 R3 sweep of byte patterns in both speed modes
        for (int m = 0; m < 2; m++) begin
            fast_mode = m[0];
            cur_q = (m == 0) ? QS : QF;
            width_n = 0; width_bad = 0;
            for (int v = 0; v < 16; v++) begin
                logic [7:0] a, d;
                a = {v[3:0], ~v[3:0]};
                d = 8'(v * 8'h11);
                clear_log(-1);
                send(1'b1, 1'b0, a);
                send(1'b0, 1'b1, d);
                wait_idle();
                check("R5 byte count", 32'(rx_n), 2);
                check("R5 address MSB first", 32'(rx[0]), 32'(a));
                check("R5 data MSB first", 32'(rx[1]), 32'(d));
                check("R5 done count", 32'(done_n), 2);
                check("R5 acks", 32'({done_ack[0], done_ack[1]}), 3);
                check("R5 no err", 32'(err), 0);
                check("R3 busy seen", 32'(busy_seen), 1);
                check("R3 busy cleared", 32'(busy), 0);
            end
            check("R2 widths measured", 32'(width_n > 0), 1);
            check("R2 SCL high width", 32'(width_bad), 0);
        end

        // R9 hold between bytes, then repeated START
        fast_mode = 1'b0;
        clear_log(-1);
        s0 = start_n; p0 = stop_n;
        send(1'b1, 1'b0, 8'h50);
        while (done_n < 1) @(negedge clk);
        repeat (100) @(negedge clk);
        check("R9 SCL held low", 32'(scl_oe), 1);
        check("R9 SDA released", 32'(sda_oe), 0);
        check("R9 busy held", 32'(busy), 1);
        check("R9 no STOP yet", 32'(stop_n - p0), 0);
        send(1'b1, 1'b0, 8'h51);
        send(1'b0, 1'b1, 8'hC3);
        wait_idle();
        check("R9 byte count", 32'(rx_n), 3);
        check("R9 byte1", 32'(rx[1]), 32'h51);
        check("R9 byte2", 32'(rx[2]), 32'hC3);
        check("R9 two STARTs", 32'(start_n - s0), 2);
        check("R9 one STOP", 32'(stop_n - p0), 1);

        // R6 R7 NACK on a data byte
        clear_log(1);
        p0 = stop_n;
        send(1'b1, 1'b0, 8'hA0);
        send(1'b0, 1'b0, 8'h11);
        send(1'b0, 1'b1, 8'h22);
        wait_idle();
        check("R6 done count", 32'(done_n), 2);
        check("R6 ack then nack", 32'({done_ack[0], done_ack[1]}), 2);
        check("R6 err set", 32'(err), 1);
        check("R6 STOP issued", 32'(stop_n - p0), 1);
        check("R7 queued byte dropped", 32'(rx_n), 2);
        check("R7 lines released", 32'({scl_oe, sda_oe}), 0);
        send(1'b0, 1'b0, 8'h33);
        repeat (60) @(negedge clk);
        check("R7 no bytes while err", 32'(rx_n), 2);
        check("R7 no done while err", 32'(done_n), 2);
        check("R7 err kept", 32'(err), 1);

        // R8 new transaction clears error
        clear_log(-1);
        send(1'b1, 1'b0, 8'h42);
        @(negedge clk);
        check("R8 err cleared on start", 32'(err), 0);
        send(1'b0, 1'b1, 8'h99);
        wait_idle();
        check("R8 bytes", 32'({rx[0], rx[1]}), 32'h4299);
        check("R8 err stays clear", 32'(err), 0);

        // R6 NACK on the address byte
        clear_log(0);
        send(1'b1, 1'b0, 8'hEE);
        send(1'b0, 1'b1, 8'h01);
        wait_idle();
        check("R6 address nack done", 32'(done_n), 1);
        check("R6 address nack ack", 32'(done_ack[0]), 0);
        check("R6 address nack err", 32'(err), 1);
        check("R7 data after address nack", 32'(rx_n), 1);

        // R10 soft reset, idle with err and mid-byte
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        check("R10 err cleared", 32'(err), 0);
        clear_log(-1);
        send(1'b1, 1'b1, 8'hFF);
        repeat (16*QS) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        check("R10 lines released", 32'({scl_oe, sda_oe}), 0);
        check("R10 busy cleared", 32'(busy), 0);
        check("R10 idle", 32'(cmd_ready), 1);
        repeat (10) @(negedge clk);
        clear_log(-1);
        send(1'b1, 1'b1, 8'h3A);
        wait_idle();
        check("R10 recovery byte", 32'(rx[0]), 32'h3A);

        // R3 START and STOP from another master
        ext_sda_low = 1'b1;
        repeat (6) @(negedge clk);
        check("R3 external START sets busy", 32'(busy), 1);
        check("R3 block stays idle", 32'({cmd_ready, scl_oe}), 2);
        ext_sda_low = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 external STOP clears busy", 32'(busy), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule